// File: doc/BRIEF.md
# Timer-Clocked Tone Output Pair

This block turns timer overflow strobes into a square-wave tone on two output pins, for example to drive a piezo buzzer. One of two up-counting timers is chosen as the clock source. Every overflow strobe from the chosen timer inverts an internal phase bit. Pin 0 carries the phase and pin 1 carries its complement. The timer's prescaler and preload value set the tone frequency: there is one phase inversion per overflow.

Each pin has a data bit and a direction bit. The data bit switches that pin's tone on and off, and a cleared data bit holds the pin low. The direction bit alone enables the pin driver. When the tone function is switched off, the pins are plain outputs that follow their data bits. The phase bit is also cleared, so the next tone burst starts from a known phase.

Top module: `pfd_tone_out`

## Requirements
- R1: `src_sel` picks the clock source: value 0 selects `tmr_ovf[0]` and value 1 selects `tmr_ovf[1]`. A strobe on the other timer has no effect on the outputs.
- R2: While `tone_en` is 1, each cycle with a strobe on the selected timer inverts the phase. The pin values change in the cycle after the clock edge that samples the strobe.
- R3: While `tone_en` is 1 and the selected timer has no strobe, the phase holds its value.
- R4: `pin_oe[k]` equals `pin_dir[k]` for every pin and in every mode (1 = drive).
- R5: A pin whose data bit `pin_dat[k]` is 0 outputs 0, with the tone on or off.
- R6: With the tone on and the data bit set, `pin_out[0]` equals the phase and `pin_out[1]` equals the inverted phase.
- R7: With `tone_en` at 0, `pin_out` equals `pin_dat` and the phase is cleared. After the tone is re-enabled with both data bits set, the outputs read pin 0 = 0 and pin 1 = 1.
- R8: A synchronous reset clears the phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_ovf | input | 2 | One-cycle overflow strobes, one per timer |
| src_sel | input | 1 | Timer select for the tone clock |
| tone_en | input | 1 | Tone function enable |
| pin_dat | input | 2 | Per-pin data bit (tone gate, or level when the tone is off) |
| pin_dir | input | 2 | Per-pin direction, 1 = output |
| pin_out | output | 2 | Pin drive values |
| pin_oe | output | 2 | Pin output enables |

## Verification
Single strobes on the selected timer check the inversion and its one-cycle latency. Strobes on the unselected timer, under each value of `src_sel`, show that source selection is real and not just an OR of both strobes. Back-to-back strobes check that every strobe counts, with none merged. Clearing single data bits and direction bits while the tone runs separates the gating path from the enable path. A disable followed by a re-enable shows that the phase really restarts from zero rather than resuming where it stopped.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef struct packed {
        logic phase;
    } pfd_state_t;

    localparam int PFD_NUM_SRC  = 2;
    localparam int PFD_NUM_PINS = 2;
endpackage

// File: rtl/pfd_tick_sel.sv
module pfd_tick_sel #(
    parameter int NUM_SRC = 2,
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] ovf,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) tick = ovf[i];
        end
    end

    AST_NO_FOREIGN_TICK: assert property (@(posedge clk) disable iff (rst)
        (ovf == '0) |-> !tick) else $error("tick without strobe"); // R1
endmodule

// File: rtl/pfd_phase_reg.sv
module pfd_phase_reg
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    output logic phase
);
    pfd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en)       st_d.phase = 1'b0;
        else if (tick) st_d.phase = ~st_q.phase;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign phase = st_q.phase;

    AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (en && tick) |=> (phase != $past(phase))) else $error("no toggle"); // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(phase)) else $error("phase drift"); // R3
    AST_CLEAR_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> !phase) else $error("phase not cleared"); // R7
    AST_RESET_PHASE: assert property (@(posedge clk)
        rst |=> !phase) else $error("phase not reset"); // R8
endmodule

// File: rtl/pfd_pin_drive.sv
module pfd_pin_drive #(
    parameter int NUM_PINS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                phase,
    input  logic [NUM_PINS-1:0] dat,
    input  logic [NUM_PINS-1:0] dir,
    output logic [NUM_PINS-1:0] out,
    output logic [NUM_PINS-1:0] oe
);
    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        localparam logic INV = logic'(k % 2);
        logic tone_k;
        assign tone_k = phase ^ INV;
        assign out[k] = dat[k] & (en ? tone_k : 1'b1);
        assign oe[k]  = dir[k];

        AST_DATA_LOW: assert property (@(posedge clk) disable iff (rst)
            !dat[k] |-> !out[k]) else $error("pin not low"); // R5
    end
endmodule

// File: rtl/pfd_tone_out.sv
module pfd_tone_out
    import pfd_pkg::*;
#(
    parameter int NUM_SRC  = PFD_NUM_SRC,
    parameter int NUM_PINS = PFD_NUM_PINS,
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  tmr_ovf,
    input  logic [SEL_W-1:0]    src_sel,
    input  logic                tone_en,
    input  logic [NUM_PINS-1:0] pin_dat,
    input  logic [NUM_PINS-1:0] pin_dir,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    logic tick;
    logic phase;

    pfd_tick_sel #(.NUM_SRC(NUM_SRC)) u_sel (
        .clk(clk), .rst(rst), .ovf(tmr_ovf), .sel(src_sel), .tick(tick)
    );

    pfd_phase_reg u_phase (
        .clk(clk), .rst(rst), .en(tone_en), .tick(tick), .phase(phase)
    );

    pfd_pin_drive #(.NUM_PINS(NUM_PINS)) u_pins (
        .clk(clk), .rst(rst), .en(tone_en), .phase(phase),
        .dat(pin_dat), .dir(pin_dir), .out(pin_out), .oe(pin_oe)
    );

    if (NUM_PINS >= 2) begin : g_pair_chk
        AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
            (tone_en && pin_dat[1:0] == 2'b11) |-> (pin_out[0] != pin_out[1]))
            else $error("pair not complementary"); // R6
    end
    AST_FOLLOW_DATA: assert property (@(posedge clk) disable iff (rst)
        !tone_en |-> (pin_out == pin_dat)) else $error("plain I/O broken"); // R7
endmodule

// File: tb/pfd_tone_out_test.sv
module pfd_tone_out_test;
    typedef struct {
        logic [1:0] out;
        logic [1:0] oe;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] tmr_ovf = '0;
    logic [0:0] src_sel = '0;
    logic       tone_en = 1'b0;
    logic [1:0] pin_dat = '0;
    logic [1:0] pin_dir = '0;
    logic [1:0] pin_out;
    logic [1:0] pin_oe;

    exp_t sb[$];
    int   n_run  = 0;
    int   n_fail = 0;
    logic m_ph   = 1'b0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    pfd_tone_out uut (
        .clk(clk), .rst(rst), .tmr_ovf(tmr_ovf), .src_sel(src_sel),
        .tone_en(tone_en), .pin_dat(pin_dat), .pin_dir(pin_dir),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // driver: applies one cycle of stimulus and pushes the post-edge expectation
    task automatic step(input logic r, input logic [1:0] ovf, input logic sel,
                        input logic en, input logic [1:0] dat, input logic [1:0] dir,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; tmr_ovf = ovf; src_sel = sel; tone_en = en;
        pin_dat = dat; pin_dir = dir;
        if (r)        m_ph = 1'b0;
        else if (!en) m_ph = 1'b0;
        else if (ovf[sel]) m_ph = ~m_ph;
        e.oe  = dir;
        e.out = en ? (dat & {~m_ph, m_ph}) : dat;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares after each edge once outputs settle
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (pin_out !== e.out || pin_oe !== e.oe) begin
                n_fail++;
                $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b",
                         e.tag, pin_out, pin_oe, e.out, e.oe);
            end
        end
    end

    initial begin
        step(1, 2'b00, 0, 0, 2'b00, 2'b00, "R8 reset");
        step(1, 2'b11, 0, 1, 2'b11, 2'b11, "R8 reset ignores strobes");
        step(0, 2'b00, 0, 0, 2'b01, 2'b11, "R7 plain data 01");
        step(0, 2'b00, 0, 0, 2'b10, 2'b10, "R7 plain data 10, R4 oe");
        step(0, 2'b00, 0, 1, 2'b11, 2'b11, "R6 start phase");
        step(0, 2'b00, 0, 1, 2'b11, 2'b11, "R3 hold");
        step(0, 2'b01, 0, 1, 2'b11, 2'b11, "R2 toggle on timer0");
        step(0, 2'b00, 0, 1, 2'b11, 2'b11, "R3 hold after toggle");
        step(0, 2'b10, 0, 1, 2'b11, 2'b11, "R1 timer1 ignored when sel=0");
        step(0, 2'b10, 1, 1, 2'b11, 2'b11, "R1 timer1 selected");
        step(0, 2'b01, 1, 1, 2'b11, 2'b11, "R1 timer0 ignored when sel=1");
        step(0, 2'b10, 1, 1, 2'b11, 2'b11, "R2 back-to-back 1");
        step(0, 2'b10, 1, 1, 2'b11, 2'b11, "R2 back-to-back 2");
        step(0, 2'b10, 1, 1, 2'b11, 2'b11, "R2 back-to-back 3");
        step(0, 2'b00, 1, 1, 2'b01, 2'b11, "R5 pin1 data low");
        step(0, 2'b10, 1, 1, 2'b10, 2'b11, "R5 pin0 data low");
        step(0, 2'b00, 1, 1, 2'b11, 2'b01, "R4 pin1 not driven");
        step(0, 2'b00, 1, 1, 2'b11, 2'b10, "R4 pin0 not driven");
        step(0, 2'b10, 1, 1, 2'b00, 2'b11, "R5 both data low");
        step(0, 2'b10, 1, 0, 2'b11, 2'b11, "R7 disable clears phase");
        step(0, 2'b00, 1, 1, 2'b11, 2'b11, "R7 restart phase");
        step(0, 2'b11, 1, 1, 2'b11, 2'b11, "R2 both strobes");
        step(1, 2'b00, 1, 1, 2'b11, 2'b11, "R8 reset mid-tone");
        step(0, 2'b00, 1, 1, 2'b11, 2'b11, "R8 phase after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: expected=done actual=hung");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule